// File: doc/BRIEF.md
# Operand Address Generation Unit

This unit forms the memory operand address for a 32-bit segmented machine. Each request carries an addressing-mode code, a base register number, an index register number, a 2-bit scale code and a displacement with a width flag. The unit also receives a flat copy of the general register file and the base of the segment already selected. It sums the terms the mode calls for into an effective address (the offset within the segment), then adds the segment base to that offset to give the linear address.

The unit takes one request per cycle over a valid/ready pair and returns the result one cycle later from output registers. A downstream stall holds the result until it is taken. Two kinds of encoding are refused: a mode code outside the nine defined ones, and a mode that names the stack pointer (register 4) as index. A refused request still produces a result beat. That beat has the illegal flag set and both addresses at zero.

Top module: `oau_top`

## Requirements
- R1: Mode 0 (direct) gives an effective address equal to the displacement alone. Base and index play no part.
- R2: The mode code selects the terms that are summed, as base / index / scale / displacement. Code 1 = B. Code 2 = B+D. Code 3 = I+D. Code 4 = I·S+D. Code 5 = B+I. Code 6 = B+I·S. Code 7 = B+I+D. Code 8 = B+I·S+D. A term the mode does not name contributes nothing.
- R3: In the scaled modes (4, 6, 8), scale code 0, 1, 2 or 3 multiplies the index by 1, 2, 4 or 8. This is a left shift of that many bits.
- R4: In the unscaled index modes (3, 5, 7), the scale code is ignored and the index is added once.
- R5: When the width flag is 0, only displacement bits [7:0] are used, sign-extended to 32 bits. Bits [31:8] are ignored. When the flag is 1, all 32 bits are used.
- R6: All sums wrap modulo 2^32, and any carry out is dropped.
- R7: The linear address equals the segment base plus the effective address, modulo 2^32.
- R8: An index-using mode (codes 3 to 8) with index register 4 gives illegal=1 and both addresses zero. Register 4 is accepted as a base. Register 4 is also accepted as an index number in modes 0 to 2, where the index is unused.
- R9: A mode code from 9 to 15 gives illegal=1 and both addresses zero.
- R10: A request is accepted when in_valid and in_ready are both high. in_ready is high when no result is pending or out_ready is high. out_valid rises in the cycle after acceptance.
- R11: While out_valid is high and out_ready is low, out_valid, both addresses and the illegal flag hold their values, and no new request is accepted.
- R12: A synchronous active-high reset clears out_valid and the illegal flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| in_valid_i | input | 1 | Request present |
| in_ready_o | output | 1 | Unit can take a request |
| mode_i | input | 4 | Addressing-mode code (0 to 8 defined) |
| base_sel_i | input | 3 | Base register number |
| index_sel_i | input | 3 | Index register number |
| scale_code_i | input | 2 | Shift amount for the index in scaled modes |
| disp_i | input | 32 | Displacement |
| disp_wide_i | input | 1 | 1 = 32-bit displacement, 0 = sign-extended byte |
| regs_i | input | 256 | Register file, register r at bits [32r+31:32r] |
| seg_base_i | input | 32 | Base of the selected segment |
| out_valid_o | output | 1 | Result present |
| out_ready_i | input | 1 | Consumer takes the result |
| eff_addr_o | output | 32 | Effective address (offset) |
| lin_addr_o | output | 32 | Linear address |
| illegal_o | output | 1 | Request encoding was refused |

## Verification
Two things can happen in the same clock edge: a held result is released and a new request is accepted. When out_ready returns high while the next request is already waiting, the output register drops the old beat and loads the new one at that edge. The bench provokes this by stalling the consumer, presenting a second request during the stall, and then releasing the stall. It checks that the first result stays unchanged throughout the stall, that the second request is not taken early, and that the edge which releases the stall shows the second request's addresses with no idle cycle in between. A second overlap is also exercised: a stack-pointer index arriving in a mode that also carries a large base and displacement. The bench expects the illegal flag to win and both addresses to read zero, not the wrapped sum.

// File: rtl/oau_pkg.sv
package oau_pkg;

    typedef enum logic [3:0] {
        AM_DIRECT           = 4'd0,
        AM_REG_IND          = 4'd1,
        AM_BASED            = 4'd2,
        AM_INDEX            = 4'd3,
        AM_SCALED           = 4'd4,
        AM_BASE_IDX         = 4'd5,
        AM_BASE_SCALED      = 4'd6,
        AM_BASE_IDX_DISP    = 4'd7,
        AM_BASE_SCALED_DISP = 4'd8
    } am_mode_e;

    typedef struct packed {
        logic known;
        logic use_base;
        logic use_index;
        logic use_scale;
        logic use_disp;
    } term_sel_t;

endpackage

// File: rtl/oau_mode_decode.sv
module oau_mode_decode
    import oau_pkg::*;
(
    input  logic [3:0] mode_i,
    output term_sel_t  sel_o
);
    always_comb begin
        sel_o = '0;
        case (mode_i)
            AM_DIRECT:           sel_o = '{known: 1'b1, use_base: 1'b0, use_index: 1'b0, use_scale: 1'b0, use_disp: 1'b1};
            AM_REG_IND:          sel_o = '{known: 1'b1, use_base: 1'b1, use_index: 1'b0, use_scale: 1'b0, use_disp: 1'b0};
            AM_BASED:            sel_o = '{known: 1'b1, use_base: 1'b1, use_index: 1'b0, use_scale: 1'b0, use_disp: 1'b1};
            AM_INDEX:            sel_o = '{known: 1'b1, use_base: 1'b0, use_index: 1'b1, use_scale: 1'b0, use_disp: 1'b1};
            AM_SCALED:           sel_o = '{known: 1'b1, use_base: 1'b0, use_index: 1'b1, use_scale: 1'b1, use_disp: 1'b1};
            AM_BASE_IDX:         sel_o = '{known: 1'b1, use_base: 1'b1, use_index: 1'b1, use_scale: 1'b0, use_disp: 1'b0};
            AM_BASE_SCALED:      sel_o = '{known: 1'b1, use_base: 1'b1, use_index: 1'b1, use_scale: 1'b1, use_disp: 1'b0};
            AM_BASE_IDX_DISP:    sel_o = '{known: 1'b1, use_base: 1'b1, use_index: 1'b1, use_scale: 1'b0, use_disp: 1'b1};
            AM_BASE_SCALED_DISP: sel_o = '{known: 1'b1, use_base: 1'b1, use_index: 1'b1, use_scale: 1'b1, use_disp: 1'b1};
            default:             sel_o = '0;
        endcase
    end
endmodule

// File: rtl/oau_reg_pick.sv
module oau_reg_pick #(
    parameter int DATA_W   = 32,
    parameter int NUM_REGS = 8,
    parameter int SEL_W    = $clog2(NUM_REGS)
) (
    input  logic [NUM_REGS*DATA_W-1:0] regs_i,
    input  logic [SEL_W-1:0]           sel_i,
    output logic [DATA_W-1:0]          val_o
);
    logic [DATA_W-1:0] bank [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_unpack
        assign bank[g] = regs_i[g*DATA_W +: DATA_W];
    end

    assign val_o = bank[sel_i];
endmodule

// File: rtl/oau_ea_sum.sv
module oau_ea_sum
    import oau_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int NARROW_W = 8,
    parameter int SCALE_W  = 2
) (
    input  term_sel_t           sel_i,
    input  logic [DATA_W-1:0]   base_i,
    input  logic [DATA_W-1:0]   index_i,
    input  logic [SCALE_W-1:0]  scale_code_i,
    input  logic [DATA_W-1:0]   disp_i,
    input  logic                disp_wide_i,
    output logic [DATA_W-1:0]   ea_o
);
    logic [DATA_W-1:0]  disp_ext;
    logic [SCALE_W-1:0] shamt;
    logic [DATA_W-1:0]  base_term;
    logic [DATA_W-1:0]  index_term;
    logic [DATA_W-1:0]  disp_term;

    always_comb begin
        disp_ext   = disp_wide_i ? disp_i
                                 : {{(DATA_W-NARROW_W){disp_i[NARROW_W-1]}}, disp_i[NARROW_W-1:0]};
        shamt      = sel_i.use_scale ? scale_code_i : '0;
        base_term  = sel_i.use_base  ? base_i : '0;
        index_term = sel_i.use_index ? (index_i << shamt) : '0;
        disp_term  = sel_i.use_disp  ? disp_ext : '0;
        ea_o       = base_term + index_term + disp_term;
    end
endmodule

// File: rtl/oau_top.sv
module oau_top
    import oau_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int NUM_REGS = 8,
    parameter int SP_REG   = 4,
    parameter int SCALE_W  = 2,
    parameter int NARROW_W = 8,
    parameter int MODE_W   = 4
) (
    input  logic                       clk_i,
    input  logic                       rst_i,
    input  logic                       in_valid_i,
    output logic                       in_ready_o,
    input  logic [MODE_W-1:0]          mode_i,
    input  logic [$clog2(NUM_REGS)-1:0] base_sel_i,
    input  logic [$clog2(NUM_REGS)-1:0] index_sel_i,
    input  logic [SCALE_W-1:0]         scale_code_i,
    input  logic [DATA_W-1:0]          disp_i,
    input  logic                       disp_wide_i,
    input  logic [NUM_REGS*DATA_W-1:0] regs_i,
    input  logic [DATA_W-1:0]          seg_base_i,
    output logic                       out_valid_o,
    input  logic                       out_ready_i,
    output logic [DATA_W-1:0]          eff_addr_o,
    output logic [DATA_W-1:0]          lin_addr_o,
    output logic                       illegal_o
);
    localparam int SEL_W = $clog2(NUM_REGS);

    typedef struct packed {
        logic              valid;
        logic              illegal;
        logic [DATA_W-1:0] ea;
        logic [DATA_W-1:0] la;
    } stage_t;

    stage_t            st_d, st_q;
    term_sel_t         sel;
    logic [DATA_W-1:0] base_val, index_val, ea_raw;
    logic              accept, bad_index;

    oau_mode_decode u_dec (
        .mode_i (mode_i),
        .sel_o  (sel)
    );

    oau_reg_pick #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .SEL_W(SEL_W)) u_base_pick (
        .regs_i (regs_i),
        .sel_i  (base_sel_i),
        .val_o  (base_val)
    );

    oau_reg_pick #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .SEL_W(SEL_W)) u_index_pick (
        .regs_i (regs_i),
        .sel_i  (index_sel_i),
        .val_o  (index_val)
    );

    oau_ea_sum #(.DATA_W(DATA_W), .NARROW_W(NARROW_W), .SCALE_W(SCALE_W)) u_sum (
        .sel_i        (sel),
        .base_i       (base_val),
        .index_i      (index_val),
        .scale_code_i (scale_code_i),
        .disp_i       (disp_i),
        .disp_wide_i  (disp_wide_i),
        .ea_o         (ea_raw)
    );

    assign in_ready_o = !st_q.valid || out_ready_i;
    assign accept     = in_valid_i && in_ready_o;
    assign bad_index  = sel.use_index && (index_sel_i == SEL_W'(SP_REG));

    always_comb begin
        st_d = st_q;
        if (accept) begin
            st_d.valid   = 1'b1;
            st_d.illegal = !sel.known || bad_index;
            if (st_d.illegal) begin
                st_d.ea = '0;
                st_d.la = '0;
            end else begin
                st_d.ea = ea_raw;
                st_d.la = seg_base_i + ea_raw;
            end
        end else if (out_ready_i) begin
            st_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign out_valid_o = st_q.valid;
    assign illegal_o   = st_q.illegal;
    assign eff_addr_o  = st_q.ea;
    assign lin_addr_o  = st_q.la;
endmodule

// File: rtl/oau_checker.sv
module oau_checker #(
    parameter int DATA_W   = 32,
    parameter int NUM_REGS = 8,
    parameter int SP_REG   = 4,
    parameter int MODE_W   = 4
) (
    input logic                        clk_i,
    input logic                        rst_i,
    input logic                        in_valid_i,
    input logic                        in_ready_o,
    input logic [MODE_W-1:0]           mode_i,
    input logic [$clog2(NUM_REGS)-1:0] index_sel_i,
    input logic [DATA_W-1:0]           seg_base_i,
    input logic                        out_valid_o,
    input logic                        out_ready_i,
    input logic [DATA_W-1:0]           eff_addr_o,
    input logic [DATA_W-1:0]           lin_addr_o,
    input logic                        illegal_o
);
    localparam int SEL_W = $clog2(NUM_REGS);
    logic accept;
    assign accept = in_valid_i && in_ready_o;

    assert_reset_clears_R12: assert property (@(posedge clk_i)
        rst_i |=> (!out_valid_o && !illegal_o));

    assert_valid_after_accept_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        accept |=> out_valid_o);

    assert_stall_blocks_R11: assert property (@(posedge clk_i) disable iff (rst_i)
        (out_valid_o && !out_ready_i) |-> !in_ready_o);

    assert_hold_on_stall_R11: assert property (@(posedge clk_i) disable iff (rst_i)
        (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(eff_addr_o)
                                           && $stable(lin_addr_o) && $stable(illegal_o)));

    assert_illegal_zero_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        (out_valid_o && illegal_o) |-> (eff_addr_o == '0 && lin_addr_o == '0));

    assert_sp_index_flag_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        (accept && mode_i >= MODE_W'(3) && mode_i <= MODE_W'(8) && index_sel_i == SEL_W'(SP_REG))
        |=> illegal_o);

    assert_undef_mode_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        (accept && mode_i > MODE_W'(8)) |=> illegal_o);

    assert_linear_sum_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        accept |=> (illegal_o || lin_addr_o == $past(seg_base_i) + eff_addr_o));
endmodule

bind oau_top oau_checker #(
    .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .SP_REG(SP_REG), .MODE_W(MODE_W)
) chk_i (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .in_valid_i  (in_valid_i),
    .in_ready_o  (in_ready_o),
    .mode_i      (mode_i),
    .index_sel_i (index_sel_i),
    .seg_base_i  (seg_base_i),
    .out_valid_o (out_valid_o),
    .out_ready_i (out_ready_i),
    .eff_addr_o  (eff_addr_o),
    .lin_addr_o  (lin_addr_o),
    .illegal_o   (illegal_o)
);

// File: tb/oau_top_tb_top.sv
`timescale 1ns/1ps
module oau_top_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid, in_ready;
    logic [3:0]  mode;
    logic [2:0]  base_sel, index_sel;
    logic [1:0]  scale_code;
    logic [31:0] disp;
    logic        disp_wide;
    logic [255:0] regs_flat;
    logic [31:0] seg_base;
    logic        out_valid, out_ready;
    logic [31:0] eff_addr, lin_addr;
    logic        illegal;

    logic [31:0] regs [8];
    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    always_comb
        for (int r = 0; r < 8; r++) regs_flat[r*32 +: 32] = regs[r];

    oau_top dut_i (
        .clk_i(clk), .rst_i(rst), .in_valid_i(in_valid), .in_ready_o(in_ready),
        .mode_i(mode), .base_sel_i(base_sel), .index_sel_i(index_sel),
        .scale_code_i(scale_code), .disp_i(disp), .disp_wide_i(disp_wide),
        .regs_i(regs_flat), .seg_base_i(seg_base), .out_valid_o(out_valid),
        .out_ready_i(out_ready), .eff_addr_o(eff_addr), .lin_addr_o(lin_addr),
        .illegal_o(illegal)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] model_ea(input logic [3:0] m, input logic [2:0] b, input logic [2:0] i,
                                              input logic [1:0] sc, input logic [31:0] d, input logic w,
                                              output logic bad);
        logic ub, ui, us, ud;
        logic [31:0] dx;
        bad = 1'b0;
        {ub, ui, us, ud} = 4'b0000;
        case (m)
            4'd0: {ub, ui, us, ud} = 4'b0001;
            4'd1: {ub, ui, us, ud} = 4'b1000;
            4'd2: {ub, ui, us, ud} = 4'b1001;
            4'd3: {ub, ui, us, ud} = 4'b0101;
            4'd4: {ub, ui, us, ud} = 4'b0111;
            4'd5: {ub, ui, us, ud} = 4'b1100;
            4'd6: {ub, ui, us, ud} = 4'b1110;
            4'd7: {ub, ui, us, ud} = 4'b1101;
            4'd8: {ub, ui, us, ud} = 4'b1111;
            default: bad = 1'b1;
        endcase
        if (ui && i == 3'd4) bad = 1'b1;
        if (bad) return 32'h0;
        dx = w ? d : {{24{d[7]}}, d[7:0]};
        return (ub ? regs[b] : 32'h0) + (ui ? regs[i] * (32'd1 << (us ? sc : 2'd0)) : 32'h0) + (ud ? dx : 32'h0);
    endfunction

    // One request with the consumer ready; checks the result beat.
    task automatic req_check(input string tag, input logic [3:0] m, input logic [2:0] b, input logic [2:0] i,
                             input logic [1:0] sc, input logic [31:0] d, input logic w, input logic [31:0] sb);
        logic bad;
        logic [31:0] e;
        @(negedge clk);
        mode = m; base_sel = b; index_sel = i; scale_code = sc; disp = d; disp_wide = w; seg_base = sb;
        in_valid = 1'b1; out_ready = 1'b1;
        e = model_ea(m, b, i, sc, d, w, bad);
        @(posedge clk); #0.5;
        in_valid = 1'b0;
        @(negedge clk);
        chk("R10", {tag, " valid"}, {31'b0, out_valid}, 32'd1);
        chk(tag, "illegal", {31'b0, illegal}, {31'b0, bad});
        chk(tag, "eff", eff_addr, e);
        chk(bad ? tag : "R7", "lin", lin_addr, bad ? 32'h0 : sb + e);
    endtask

    task automatic t_reset();
        rst = 1'b1; in_valid = 1'b0; out_ready = 1'b1;
        mode = '0; base_sel = '0; index_sel = '0; scale_code = '0; disp = '0; disp_wide = 1'b0; seg_base = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R12", "valid after reset", {31'b0, out_valid}, 32'd0);
        chk("R12", "illegal after reset", {31'b0, illegal}, 32'd0);
        chk("R10", "ready after reset", {31'b0, in_ready}, 32'd1);
        rst = 1'b0;
    endtask

    task automatic t_direct();
        req_check("R1", 4'd0, 3'd1, 3'd2, 2'd3, 32'h0000_1234, 1'b1, 32'h0);
        req_check("R5", 4'd0, 3'd0, 3'd0, 2'd0, 32'hABCD_EF80, 1'b0, 32'h0);   // narrow -128
        req_check("R5", 4'd0, 3'd0, 3'd0, 2'd0, 32'hFFFF_FF7F, 1'b0, 32'h0);   // narrow +127
    endtask

    task automatic t_modes();
        for (int m = 0; m < 9; m++)
            req_check("R2", 4'(m), 3'd2, 3'd3, 2'd1, 32'h0000_0040, 1'b1, 32'h0001_0000);
    endtask

    task automatic t_scale();
        for (int s = 0; s < 4; s++) begin
            req_check("R3", 4'd4, 3'd0, 3'd5, 2'(s), 32'h0000_0010, 1'b0, 32'h0);
            req_check("R3", 4'd8, 3'd1, 3'd6, 2'(s), 32'hFFFF_FFF0, 1'b0, 32'h0);
        end
    endtask

    task automatic t_scale_ignored();
        req_check("R4", 4'd3, 3'd0, 3'd5, 2'd3, 32'h0000_0010, 1'b1, 32'h0);
        req_check("R4", 4'd5, 3'd1, 3'd5, 2'd2, 32'h0, 1'b1, 32'h0);
        req_check("R4", 4'd7, 3'd1, 3'd5, 2'd1, 32'h0000_0008, 1'b1, 32'h0);
    endtask

    task automatic t_wrap();
        req_check("R6", 4'd8, 3'd7, 3'd6, 2'd3, 32'hF000_0000, 1'b1, 32'hFFFF_0000);
        req_check("R6", 4'd2, 3'd7, 3'd0, 2'd0, 32'h0000_0020, 1'b1, 32'h0);
    endtask

    task automatic t_linear();
        req_check("R7", 4'd2, 3'd3, 3'd0, 2'd0, 32'h0000_0004, 1'b0, 32'h8000_0000);
        req_check("R7", 4'd1, 3'd1, 3'd0, 2'd0, 32'h0, 1'b1, 32'hFFFF_FFFF);
    endtask

    task automatic t_sp();
        req_check("R8", 4'd8, 3'd7, 3'd4, 2'd2, 32'h7FFF_FFFF, 1'b1, 32'h1234_0000);
        req_check("R8", 4'd3, 3'd0, 3'd4, 2'd0, 32'h10, 1'b1, 32'h0);
        req_check("R8", 4'd2, 3'd4, 3'd4, 2'd0, 32'h10, 1'b1, 32'h100);   // SP as base, index unused
        req_check("R8", 4'd1, 3'd4, 3'd4, 2'd0, 32'h0, 1'b1, 32'h0);
    endtask

    task automatic t_undef();
        req_check("R9", 4'd9,  3'd1, 3'd2, 2'd0, 32'h10, 1'b1, 32'h100);
        req_check("R9", 4'd15, 3'd1, 3'd2, 2'd0, 32'h10, 1'b1, 32'h100);
    endtask

    task automatic t_stall();
        logic bad;
        logic [31:0] ea_a, ea_b;
        ea_a = model_ea(4'd2, 3'd1, 3'd0, 2'd0, 32'h11, 1'b1, bad);
        ea_b = model_ea(4'd6, 3'd2, 3'd3, 2'd2, 32'h0, 1'b1, bad);
        @(negedge clk);
        out_ready = 1'b0; in_valid = 1'b1;
        mode = 4'd2; base_sel = 3'd1; index_sel = 3'd0; scale_code = 2'd0; disp = 32'h11; disp_wide = 1'b1;
        seg_base = 32'h0;
        @(negedge clk);
        chk("R10", "valid after accept", {31'b0, out_valid}, 32'd1);
        chk("R11", "ready low while stalled", {31'b0, in_ready}, 32'd0);
        mode = 4'd6; base_sel = 3'd2; index_sel = 3'd3; scale_code = 2'd2; disp = 32'h0;
        repeat (3) @(negedge clk);
        chk("R11", "valid held", {31'b0, out_valid}, 32'd1);
        chk("R11", "eff held", eff_addr, ea_a);
        chk("R11", "lin held", lin_addr, ea_a);
        out_ready = 1'b1;
        @(posedge clk); #0.5;
        in_valid = 1'b0;
        @(negedge clk);
        chk("R10", "back-to-back valid", {31'b0, out_valid}, 32'd1);
        chk("R10", "back-to-back eff", eff_addr, ea_b);
        @(negedge clk);
        chk("R10", "drains", {31'b0, out_valid}, 32'd0);
    endtask

    initial begin
        #(200000 * 5.0);
        n_bad++;
        $display("FAIL watchdog: actual running expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int r = 0; r < 8; r++) regs[r] = 32'h0010_0000 * (r + 1) + 32'h0000_0100 * r;
        regs[7] = 32'hFFFF_FFF0;
        regs[6] = 32'h3000_0001;
        t_reset();
        t_direct();
        t_modes();
        t_scale();
        t_scale_ignored();
        t_wrap();
        t_linear();
        t_sp();
        t_undef();
        t_stall();
        rst = 1'b1;
        @(negedge clk);
        chk("R12", "valid cleared by later reset", {31'b0, out_valid}, 32'd0);
        chk("R12", "illegal cleared by later reset", {31'b0, illegal}, 32'd0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule